// File: doc/BRIEF.md
# Ping-Pong Descriptor DMA Channel

This block is a single one-shot byte DMA channel that holds two complete descriptor sets. Each set has a buffer address, a byte count and a command word. One set is active and drives the transfer engine. The other set is idle, and software may rewrite it at any time. When software requests a swap, or when the active set finishes and the idle set is already armed, the roles exchange and the newly active set starts.

Data moves one byte at a time. In the device-to-memory direction, a byte is taken from the inbound device stream and then written to memory. In the memory-to-device direction, a byte is read from memory and then offered on the outbound device stream. After each delivered byte the active address goes up by one and the count goes down by one. A transfer stops when the count runs out and is not restarted by the block.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset all descriptor registers, the status word, the per-set done outputs and all request outputs (`mem_valid_o`, `in_ready_o`, `out_valid_o`) are zero, and set 0 is the active set.
- R2: Register map: set s occupies offsets 0x10*s, with the address at +0x0, the byte count at +0x4 and the command at +0x8. Command bit 0 is the enable and bit 1 is the direction (0 = device to memory, 1 = memory to device). Status at 0x20 has bit0/bit1 = done of set 0/1, bit2 = error, bit3 = active set index and bit4 = busy. Control at 0x24 has bit0 = swap request.
- R3: In direction 0, each byte accepted from the inbound stream is written to memory at consecutive addresses, starting at the set's address.
- R4: In direction 1, bytes read from consecutive memory addresses, starting at the set's address, are presented on the outbound stream in order.
- R5: Each delivered byte increments the active address by one and decrements the count by one. When the transfer ends, the address reads base+length and the count reads 0.
- R6: When the count of the active set reaches zero, its enable bit clears and its done flag (status and `done_o`) is set. The flag stays set until 1 is written to its status bit. An enabled set with a count of 0 completes without moving any data.
- R7: A write to any register of the active set while its enable bit is set has no effect and latches the status error bit. Writing 1 to status bit2 clears the error. Writes to the idle set are always accepted.
- R8: A swap request while the engine is idle makes the other set active, and that set starts at once if it is enabled. A swap request while busy is ignored and latches the error bit.
- R9: If the idle set is enabled when the active set completes, the sets swap automatically. The first request of the new set follows the last handshake of the old set with no idle cycle between them.
- R10: At most one of `mem_valid_o`, `in_ready_o` and `out_valid_o` is high at a time. A memory request or an outbound byte stays asserted and unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ready_i | input | 1 | Memory accepts request; read data valid in the same cycle |
| mem_rdata_i | input | 8 | Memory read byte |
| in_valid_i | input | 1 | Inbound device byte valid |
| in_data_i | input | 8 | Inbound device byte |
| in_ready_o | output | 1 | Inbound byte accepted |
| out_valid_o | output | 1 | Outbound device byte valid |
| out_data_o | output | 8 | Outbound device byte |
| out_ready_i | input | 1 | Device accepts outbound byte |
| done_o | output | 2 | Sticky completion flag per set |

## Verification
The bench sweeps both sets, both directions and lengths from one to five, with and without back-pressure. This catches an off-by-one end count, which would move one byte too many or too few and leave the count register non-zero. A chained pair of sets is timed from the first outbound byte to the last. A design that inserted an idle cycle at the automatic swap would stretch that span past two cycles per byte. The bench also writes to the active set in the middle of a transfer and swaps while busy. A design that let either of these through would corrupt the running address or change the active set index. The zero-length case and the W1C done and error flags are checked at the register port.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;
  localparam int RA_W   = 6;
  localparam int N_SET  = 2;
  localparam int CMD_EN  = 0;
  localparam int CMD_DIR = 1;
  localparam logic [RA_W-1:0] OFS_STAT = 6'h20;
  localparam logic [RA_W-1:0] OFS_CTRL = 6'h24;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_DELIVER = 2'd2
  } eng_state_e;

  typedef enum logic [1:0] {
    F_ADDR = 2'd0,
    F_LEN  = 2'd1,
    F_CMD  = 2'd2,
    F_NONE = 2'd3
  } fld_e;
endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  fld_e             fld_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic             fin_i,
  input  logic             clr_done_i,
  output logic [AW-1:0]    addr_o,
  output logic [LW-1:0]    len_o,
  output logic [1:0]       cmd_o,
  output logic             done_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [1:0]    cmd_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
      cmd_q  <= '0;
    end else if (step_i || fin_i) begin
      if (step_i) begin
        addr_q <= addr_q + AW'(1);
        len_q  <= len_q - LW'(1);
      end
      if (fin_i) cmd_q[CMD_EN] <= 1'b0;
    end else if (wr_i) begin
      unique case (fld_i)
        F_ADDR:  addr_q <= wdata_i[AW-1:0];
        F_LEN:   len_q  <= wdata_i[LW-1:0];
        F_CMD:   cmd_q  <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (fin_i)      done_q <= 1'b1;
    else if (clr_done_i) done_q <= 1'b0;
  end

  assign addr_o = addr_q;
  assign len_o  = len_q;
  assign cmd_o  = cmd_q;
  assign done_o = done_q;
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [RA_W-1:0]             addr_i,
  input  logic [REG_W-1:0]            wdata_i,
  input  logic                        act_sel_i,
  input  logic                        busy_i,
  input  logic [N_SET-1:0][AW-1:0]    set_addr_i,
  input  logic [N_SET-1:0][LW-1:0]    set_len_i,
  input  logic [N_SET-1:0][1:0]       set_cmd_i,
  input  logic [N_SET-1:0]            done_i,
  output logic [N_SET-1:0]            set_wr_o,
  output fld_e                        fld_o,
  output logic [N_SET-1:0]            clr_done_o,
  output logic                        flip_o,
  output logic                        err_o,
  output logic [REG_W-1:0]            rdata_o
);
  logic           in_sets;
  logic           sel;
  fld_e           fld;
  logic           wr_stat, wr_ctrl;
  logic           blocked_any, flip_busy;
  logic           err_q;

  assign in_sets = (addr_i[RA_W-1:5] == '0);
  assign sel     = addr_i[4];
  assign fld     = fld_e'(addr_i[3:2]);
  assign wr_stat = wr_i && (addr_i == OFS_STAT);
  assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
  assign fld_o   = fld;

  always_comb begin
    set_wr_o    = '0;
    blocked_any = 1'b0;
    for (int s = 0; s < N_SET; s++) begin
      if (wr_i && in_sets && (fld != F_NONE) && (sel == s[0])) begin
        if ((act_sel_i == s[0]) && set_cmd_i[s][CMD_EN]) blocked_any = 1'b1;
        else                                             set_wr_o[s] = 1'b1;
      end
    end
  end

  assign flip_busy = wr_ctrl && wdata_i[0] && busy_i;
  assign flip_o    = wr_ctrl && wdata_i[0] && !busy_i;

  for (genvar g = 0; g < N_SET; g++) begin : g_clr
    assign clr_done_o[g] = wr_stat && wdata_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       err_q <= 1'b0;
    else if (blocked_any || flip_busy) err_q <= 1'b1;
    else if (wr_stat && wdata_i[2])    err_q <= 1'b0;
  end
  assign err_o = err_q;

  always_comb begin
    rdata_o = '0;
    if (in_sets) begin
      unique case (fld)
        F_ADDR:  rdata_o[AW-1:0] = set_addr_i[sel];
        F_LEN:   rdata_o[LW-1:0] = set_len_i[sel];
        F_CMD:   rdata_o[1:0]    = set_cmd_i[sel];
        default: ;
      endcase
    end else if (addr_i == OFS_STAT) begin
      rdata_o[4:0] = {busy_i, act_sel_i, err_q, done_i};
    end
  end
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flip_i,
  input  logic [AW-1:0]     act_addr_i,
  input  logic [LW-1:0]     act_len_i,
  input  logic [1:0]        act_cmd_i,
  input  logic              oth_en_i,
  input  logic              oth_len_nz_i,
  output logic              act_sel_o,
  output logic              busy_o,
  output logic              step_o,
  output logic              fin_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  eng_state_e        st_q;
  logic              sel_q;
  logic [BYTE_W-1:0] byte_q;
  logic              dir, en, last;
  logic              fetch_hs, deliver_hs, swap;

  assign dir  = act_cmd_i[CMD_DIR];
  assign en   = act_cmd_i[CMD_EN];
  assign last = (act_len_i == LW'(1));

  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    unique case (st_q)
      ST_FETCH: begin
        if (dir) mem_valid_o = 1'b1;
        else     in_ready_o  = 1'b1;
      end
      ST_DELIVER: begin
        if (dir) out_valid_o = 1'b1;
        else begin
          mem_valid_o = 1'b1;
          mem_we_o    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign fetch_hs   = (st_q == ST_FETCH)   && (dir ? mem_ready_i : in_valid_i);
  assign deliver_hs = (st_q == ST_DELIVER) && (dir ? out_ready_i : mem_ready_i);
  assign step_o     = deliver_hs;
  // zero-length enabled set completes straight from idle
  assign fin_o      = (deliver_hs && last) ||
                      ((st_q == ST_IDLE) && !flip_i && en && (act_len_i == '0));
  assign swap       = fin_o && oth_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (flip_i) sel_q <= ~sel_q;
          else if (fin_o) begin
            if (swap) begin
              sel_q <= ~sel_q;
              if (oth_len_nz_i) st_q <= ST_FETCH;
            end
          end else if (en) st_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (fetch_hs) begin
            byte_q <= dir ? mem_rdata_i : in_data_i;
            st_q   <= ST_DELIVER;
          end
        end
        ST_DELIVER: begin
          if (deliver_hs) begin
            if (fin_o) begin
              if (swap) sel_q <= ~sel_q;
              st_q <= (swap && oth_len_nz_i) ? ST_FETCH : ST_IDLE;
            end else begin
              st_q <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign act_sel_o   = sel_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign mem_addr_o  = act_addr_i;
  assign mem_wdata_o = byte_q;
  assign out_data_o  = byte_q;
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic [N_SET-1:0]  done_o
);
  logic [N_SET-1:0][AW-1:0] set_addr;
  logic [N_SET-1:0][LW-1:0] set_len;
  logic [N_SET-1:0][1:0]    set_cmd;
  logic [N_SET-1:0]         set_wr, clr_done;
  fld_e                     fld;
  logic                     act_sel, oth_sel, eng_busy, eng_step, eng_fin;
  logic                     flip_req, reg_err;

  assign oth_sel = ~act_sel;

  pp_dma_regs #(.AW(AW), .LW(LW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .act_sel_i  (act_sel),
    .busy_i     (eng_busy),
    .set_addr_i (set_addr),
    .set_len_i  (set_len),
    .set_cmd_i  (set_cmd),
    .done_i     (done_o),
    .set_wr_o   (set_wr),
    .fld_o      (fld),
    .clr_done_o (clr_done),
    .flip_o     (flip_req),
    .err_o      (reg_err),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < N_SET; g++) begin : g_set
    pp_dma_desc #(.AW(AW), .LW(LW)) i_desc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (set_wr[g]),
      .fld_i      (fld),
      .wdata_i    (reg_wdata_i),
      .step_i     (eng_step && (act_sel == g[0])),
      .fin_i      (eng_fin && (act_sel == g[0])),
      .clr_done_i (clr_done[g]),
      .addr_o     (set_addr[g]),
      .len_o      (set_len[g]),
      .cmd_o      (set_cmd[g]),
      .done_o     (done_o[g])
    );
  end

  pp_dma_engine #(.AW(AW), .LW(LW)) i_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flip_i       (flip_req),
    .act_addr_i   (set_addr[act_sel]),
    .act_len_i    (set_len[act_sel]),
    .act_cmd_i    (set_cmd[act_sel]),
    .oth_en_i     (set_cmd[oth_sel][CMD_EN]),
    .oth_len_nz_i (|set_len[oth_sel]),
    .act_sel_o    (act_sel),
    .busy_o       (eng_busy),
    .step_o       (eng_step),
    .fin_o        (eng_fin),
    .mem_valid_o  (mem_valid_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rdata_i  (mem_rdata_i),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_ready_o   (in_ready_o),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i)
  );
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk
  import pp_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [BYTE_W-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic [N_SET-1:0]  done_o,
  input logic              act_sel,
  input logic              eng_busy,
  input logic              eng_fin,
  input logic              reg_err
);
  logic clr0, clr1, clr_err;
  assign clr0    = reg_wr_i && (reg_addr_i == OFS_STAT) && reg_wdata_i[0];
  assign clr1    = reg_wr_i && (reg_addr_i == OFS_STAT) && reg_wdata_i[1];
  assign clr_err = reg_wr_i && (reg_addr_i == OFS_STAT) && reg_wdata_i[2];

  a_r10_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_valid_o, in_ready_o, out_valid_o}));

  a_r10_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r6_done0_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o[0] && !clr0 |=> done_o[0]);

  a_r6_done1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o[1] && !clr1 |=> done_o[1]);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err && !clr_err |=> reg_err);

  a_r8_no_swap_mid_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy && !eng_fin |=> $stable(act_sel));
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_valid_o (mem_valid_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .done_o      (done_o),
  .act_sel     (act_sel),
  .eng_busy    (eng_busy),
  .eng_fin     (eng_fin),
  .reg_err     (reg_err)
);

// File: tb/test_pp_dma_chan.sv
module test_pp_dma_chan;
  localparam int AW = 32;
  localparam logic [5:0] STAT = 6'h20;
  localparam logic [5:0] CTRL = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_data, out_data;
  logic [1:0]  done;

  logic [7:0]  mem [256];
  logic [7:0]  snk [512];
  int          snk_cyc [512];
  int          snk_cnt = 0;
  int          src_cnt = 0;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          stall_mode = 1'b0;
  bit          block_sink = 1'b0;

  always #2 clk = ~clk;

  pp_dma_chan #(.AW(AW)) i_pp_dma_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .done_o(done)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  assign in_data   = 8'hA0 + src_cnt[7:0];

  always @(negedge clk) begin
    mem_ready <= !(stall_mode && (cyc % 3 == 0));
    in_valid  <= !(stall_mode && (cyc % 4 == 1));
    out_ready <= !block_sink && !(stall_mode && (cyc % 3 == 2));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) src_cnt <= src_cnt + 1;
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (out_valid && out_ready) begin
      snk[snk_cnt]     <= out_data;
      snk_cyc[snk_cnt] <= cyc;
      snk_cnt          <= snk_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input int s);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(STAT, v);
      if (v[s]) return;
    end
    chk(1'b0, "R6 timeout", 32'(v), 32'(1 << s));
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'(8'h30 + i * 7 + len * 16);
  endfunction

  task automatic run_one(input int s, input int dir, input int len, input bit stall);
    logic [31:0] v;
    int base, src0, snk0;
    logic [5:0] so;
    so = 6'(s * 16);
    base = s * 128 + dir * 64 + len * 8;
    stall_mode = stall;
    rd(STAT, v);
    if (v[3] != s[0]) wr(CTRL, 32'h1);
    rd(STAT, v);
    chk(v[3] == s[0], "R8 swap when idle", 32'(v[3]), 32'(s));
    for (int i = 0; i < len; i++) mem[base + i] = (dir != 0) ? pat(i, len) : 8'h00;
    src0 = src_cnt; snk0 = snk_cnt;
    wr(so + 6'h0, 32'(base));
    wr(so + 6'h4, 32'(len));
    wr(so + 6'h8, 32'((dir << 1) | 1));
    wait_done(s);
    repeat (2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (dir == 0) chk(mem[base + i] == 8'(8'hA0 + src0 + i), "R3 mem byte",
                        32'(mem[base + i]), 32'(8'(8'hA0 + src0 + i)));
      else          chk(snk[snk0 + i] == pat(i, len), "R4 out byte",
                        32'(snk[snk0 + i]), 32'(pat(i, len)));
    end
    if (dir == 0) chk(src_cnt - src0 == len, "R3 byte count", 32'(src_cnt - src0), 32'(len));
    else          chk(snk_cnt - snk0 == len, "R4 byte count", 32'(snk_cnt - snk0), 32'(len));
    rd(so + 6'h0, v); chk(v == 32'(base + len), "R5 end address", v, 32'(base + len));
    rd(so + 6'h4, v); chk(v == 0, "R5 end count", v, 0);
    rd(so + 6'h8, v); chk(v == 32'(dir << 1), "R6 enable cleared", v, 32'(dir << 1));
    chk(done[s] == 1'b1, "R6 done_o", 32'(done), 32'(1 << s));
    wr(STAT, 32'(1 << s));
    rd(STAT, v); chk(v[s] == 1'b0, "R6 W1C done", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, base0, base1;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem_ready = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(STAT, v); chk(v == 0, "R1 status", v, 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(6'(a), v); chk(v == 0, "R1 register", v, 0);
    end
    chk({mem_valid, in_ready, out_valid, done} == 0, "R1 outputs",
        32'({mem_valid, in_ready, out_valid, done}), 0);

    // R2..R6 sweep over set, direction, length, back-pressure
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int l = 1; l <= 5; l++)
          run_one(s, d, l, (l % 2) == 1);

    // R9 automatic swap with no gap (no back-pressure)
    stall_mode = 1'b0;
    rd(STAT, v);
    if (v[3] != 1'b0) wr(CTRL, 32'h1);
    base0 = 8'hD0; base1 = 8'hC0;
    for (int i = 0; i < 3; i++) mem[base1 + i] = 8'(8'h50 + i);
    for (int i = 0; i < 2; i++) mem[base0 + i] = 8'(8'h60 + i);
    s0 = snk_cnt;
    wr(6'h10, 32'(base1)); wr(6'h14, 3); wr(6'h18, 3);
    wr(6'h00, 32'(base0)); wr(6'h04, 2); wr(6'h08, 3);
    wait_done(1);
    repeat (2) @(negedge clk);
    chk(done == 2'b11, "R9 both done", 32'(done), 3);
    chk(snk_cnt - s0 == 5, "R9 byte count", 32'(snk_cnt - s0), 5);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] e;
      e = (i < 2) ? 8'(8'h60 + i) : 8'(8'h50 + i - 2);
      chk(snk[s0 + i] == e, "R9 order", 32'(snk[s0 + i]), 32'(e));
    end
    chk(snk_cyc[s0 + 4] - snk_cyc[s0] == 8, "R9 no gap",
        32'(snk_cyc[s0 + 4] - snk_cyc[s0]), 8);
    rd(STAT, v); chk(v[3] == 1'b1, "R9 active after swap", 32'(v[3]), 1);
    wr(STAT, 32'h3);

    // R7/R8 protected writes and swap while busy
    block_sink = 1'b1;
    for (int i = 0; i < 4; i++) mem[8'hE0 + i] = 8'(8'h70 + i);
    s0 = snk_cnt;
    wr(6'h10, 32'hE0); wr(6'h14, 4); wr(6'h18, 3);
    repeat (5) @(negedge clk);
    wr(6'h10, 32'hDEAD);
    rd(6'h10, v); chk(v == 32'hE0, "R7 active write ignored", v, 32'hE0);
    rd(STAT, v); chk(v[2] == 1'b1, "R7 error latched", 32'(v[2]), 1);
    wr(STAT, 32'h4);
    rd(STAT, v); chk(v[2] == 1'b0, "R7 error W1C", 32'(v[2]), 0);
    wr(CTRL, 32'h1);
    rd(STAT, v); chk(v[4:2] == 3'b111, "R8 busy swap ignored, error", 32'(v[4:2]), 7);
    wr(STAT, 32'h4);
    wr(6'h04, 32'h9);
    rd(6'h04, v); chk(v == 32'h9, "R7 idle set writable", v, 9);
    block_sink = 1'b0;
    wait_done(1);
    repeat (2) @(negedge clk);
    chk(snk_cnt - s0 == 4, "R4 count after stall", 32'(snk_cnt - s0), 4);
    chk(snk[s0 + 3] == 8'h73, "R4 last byte after stall", 32'(snk[s0 + 3]), 32'h73);
    wr(STAT, 32'h3);

    // R6 zero length
    s0 = snk_cnt;
    wr(6'h10, 32'hF0); wr(6'h14, 0); wr(6'h18, 3);
    repeat (4) @(negedge clk);
    chk(done[1] == 1'b1, "R6 zero length done", 32'(done), 2);
    rd(6'h18, v); chk(v == 32'h2, "R6 zero length enable cleared", v, 2);
    rd(6'h10, v); chk(v == 32'hF0, "R6 zero length address", v, 32'hF0);
    chk(snk_cnt == s0, "R6 zero length no data", 32'(snk_cnt), 32'(s0));
    wr(STAT, 32'h3);

    // R8 idle set armed does not run until swapped in
    s0 = src_cnt;
    wr(6'h00, 32'h20); wr(6'h04, 2); wr(6'h08, 1);
    repeat (6) @(negedge clk);
    chk(src_cnt == s0, "R8 idle set stays idle", 32'(src_cnt), 32'(s0));
    wr(CTRL, 32'h1);
    wait_done(0);
    repeat (2) @(negedge clk);
    chk(mem[8'h21] == 8'(8'hA0 + s0 + 1), "R8 swapped-in set runs",
        32'(mem[8'h21]), 32'(8'(8'hA0 + s0 + 1)));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule